// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block shapes the clock line and the data-change instant for one I2C master bit at a time. A controller above it (byte shifter, acknowledge and start/stop logic) asks for a bit by pulsing `bit_start` with the value in `bit_val`. The block pulls SCL low, counts out a programmable low phase, moves SDA a programmable hold time after the falling edge, releases SCL for a programmable high phase, and then either stops with SCL released or, if another request is waiting in the last high cycle, goes on to the next bit with no gap. All timing counts are whole system-clock cycles.

Three 8-bit settings control the waveform: a high-phase value H, a low-phase value L and a hold value D. The low phase lasts 4·L+2 cycles and the high phase 4·H+2 cycles, so a continuous bit stream has a period of 4·(L+H)+4 cycles. SDA moves D+2 cycles after the falling edge. If that point would land at or past the end of the low phase, it is pulled in to the last low cycle, so SDA never moves while SCL is released. One-cycle strobes mark the falling edge, the rising edge (where a master samples the line) and the SDA update. Settings are written through a simple strobe-and-select port. A new value only takes effect when the next phase of its kind begins.

Both line outputs are pull-low enables for open-drain pads. A 1 drives the wire low and a 0 releases it. When `en` is low the sequencer is held cleared and both wires are released.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset the settings are H=0x3F, L=0x3F and D=0x01, and both `scl_oe` and `sda_oe` are 0. The first bit therefore has a 254-cycle low phase, its SDA update 3 cycles after the fall, and a 254-cycle high phase.
- R2: `scl_oe` is 1 for exactly 4·L+2 consecutive cycles per bit, and `rise_stb` comes 4·L+2 cycles after `fall_stb`.
- R3: The high phase (`scl_oe`=0) lasts 4·H+2 cycles. With back-to-back bits, successive `fall_stb` pulses are 4·(L+H)+4 cycles apart.
- R4: `sda_stb` pulses D+2 cycles after `fall_stb` when D+2 < 4·L+2. In that same cycle `sda_oe` takes the inverse of the requested bit: bit 0 gives `sda_oe`=1, bit 1 gives `sda_oe`=0.
- R5: When D+2 ≥ 4·L+2, the SDA update (`sda_stb` and the new `sda_oe`) happens in the last low cycle, 4·L+1 cycles after `fall_stb`.
- R6: While enabled, `sda_oe` changes only in a cycle where `scl_oe` was 1 in the previous cycle and is still 1.
- R7: `fall_stb` is a one-cycle pulse in the first cycle that `scl_oe` is 1. `rise_stb` is a one-cycle pulse in the first cycle that `scl_oe` is back at 0. At most one of `fall_stb`, `rise_stb` and `sda_stb` is high in any cycle. Every strobe belongs to a requested bit.
- R8: A `bit_start` accepted while idle makes `fall_stb` appear in the next cycle. A `bit_start` held during the last high cycle starts the next bit immediately. Otherwise the block goes idle after the high phase, with `scl_oe`=0, `sda_oe` unchanged and no strobes.
- R9: Settings are written with `reg_we`=1, using `reg_sel` 0 for H, 1 for L and 2 for D. A write during a phase leaves that phase's length unchanged. A new L or D applies from the next low phase, and a new H applies from the next high phase.
- R10: One cycle after `en` is seen low, `scl_oe` and `sda_oe` are 0 and any bit in progress is dropped. While `en` is low, `bit_start` produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low clears the sequencer and releases both lines |
| bit_start | input | 1 | Request for one bit |
| bit_val | input | 1 | Bit value to place on SDA, taken with `bit_start` |
| reg_we | input | 1 | Setting write strobe |
| reg_sel | input | 2 | Setting select: 0 high, 1 low, 2 hold |
| reg_wdata | input | 8 | Setting write value |
| scl_oe | output | 1 | SCL pull-low enable |
| sda_oe | output | 1 | SDA pull-low enable |
| fall_stb | output | 1 | One-cycle pulse at each SCL falling edge |
| rise_stb | output | 1 | One-cycle pulse at each SCL rising edge |
| sda_stb | output | 1 | One-cycle pulse when SDA takes its new value |

## Verification
Two functions can land in the same cycle. When the hold setting reaches the end of the low phase, the SDA update and the low counter's terminal count share the final low cycle, and SCL rises in the very next cycle. The bench provokes this with L=1 and D=4 (exactly at the limit), with D=20 (well past it) and with L=D=0. The scoreboard requires the SDA strobe exactly 4·L+1 cycles after the fall and the rise one cycle later, while the monitor flags any SDA movement outside a low phase. A second coincidence comes from back-to-back requests: the end of a high phase and a new bit request meet in one cycle. That case is judged by the spacing between successive falling strobes, including across register writes made in the middle of a phase.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  // setting slot indices, equal to the reg_sel codes
  localparam int IDX_HIGH = 0;
  localparam int IDX_LOW  = 1;
  localparam int IDX_HOLD = 2;
  localparam int NREG     = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } bt_state_e;
endpackage

// File: rtl/bt_regfile.sv
module bt_regfile #(
  parameter int DW       = 8,
  parameter int HIGH_RST = 8'h3F,
  parameter int LOW_RST  = 8'h3F,
  parameter int HOLD_RST = 8'h01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] high_q,
  output logic [DW-1:0] low_q,
  output logic [DW-1:0] hold_q
);
  import i2c_bt_pkg::*;

  localparam logic [NREG*DW-1:0] RST_VEC =
    {DW'(HOLD_RST), DW'(LOW_RST), DW'(HIGH_RST)};

  logic [DW-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[i] <= RST_VEC[i*DW +: DW];
      else if (we && sel == 2'(i))
        regs_q[i] <= wdata;
    end
  end

  assign high_q = regs_q[IDX_HIGH];
  assign low_q  = regs_q[IDX_LOW];
  assign hold_q = regs_q[IDX_HOLD];
endmodule

// File: rtl/bt_phase_calc.sv
module bt_phase_calc #(
  parameter int DW = 8,
  localparam int CW = DW + 2
) (
  input  logic [DW-1:0] high_v,
  input  logic [DW-1:0] low_v,
  input  logic [DW-1:0] hold_v,
  output logic [CW-1:0] low_last,
  output logic [CW-1:0] high_last,
  output logic [CW-1:0] sda_at
);
  logic [CW-1:0] hold_plus2;

  // terminal counts: a phase spans counter values 0 .. 4*v+1
  assign low_last   = {low_v, 2'b01};
  assign high_last  = {high_v, 2'b01};
  assign hold_plus2 = CW'(hold_v) + CW'(2);

  // pull the SDA update into the last low cycle when the hold reaches it
  assign sda_at = (hold_plus2 > low_last) ? low_last : hold_plus2;
endmodule

// File: rtl/bt_seq.sv
module bt_seq #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          bit_start,
  input  logic          bit_val,
  input  logic [CW-1:0] low_last,
  input  logic [CW-1:0] high_last,
  input  logic [CW-1:0] sda_at,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          fall_stb,
  output logic          rise_stb,
  output logic          sda_stb
);
  import i2c_bt_pkg::*;

  bt_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] sda_at_q;
  logic          bit_q;
  logic          en_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      lim_q    <= '0;
      sda_at_q <= '0;
      bit_q    <= 1'b1;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      sda_stb  <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      sda_stb  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (bit_start) begin
            state_q  <= ST_LOW;
            cnt_q    <= '0;
            lim_q    <= low_last;
            sda_at_q <= sda_at;
            bit_q    <= bit_val;
            scl_oe   <= 1'b1;
            fall_stb <= 1'b1;
          end
        end
        ST_LOW: begin
          cnt_q <= cnt_nx;
          if (cnt_nx == sda_at_q) begin
            sda_oe  <= ~bit_q;
            sda_stb <= 1'b1;
          end
          if (cnt_q == lim_q) begin
            state_q  <= ST_HIGH;
            cnt_q    <= '0;
            lim_q    <= high_last;
            scl_oe   <= 1'b0;
            rise_stb <= 1'b1;
          end
        end
        ST_HIGH: begin
          cnt_q <= cnt_nx;
          if (cnt_q == lim_q) begin
            cnt_q <= '0;
            if (bit_start) begin
              state_q  <= ST_LOW;
              lim_q    <= low_last;
              sda_at_q <= sda_at;
              bit_q    <= bit_val;
              scl_oe   <= 1'b1;
              fall_stb <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: data line moves only inside a low phase
  p_sda_low_only_r6: assert property (@(posedge clk) disable iff (rst || !en || !en_q)
    (sda_oe != $past(sda_oe)) |-> (scl_oe && $past(scl_oe)));

  // R7: falling strobe marks the first pulled-low cycle
  p_fall_edge_r7: assert property (@(posedge clk) disable iff (rst || !en || !en_q)
    fall_stb |-> (scl_oe && !$past(scl_oe)));

  // R7: rising strobe marks the first released cycle
  p_rise_edge_r7: assert property (@(posedge clk) disable iff (rst || !en || !en_q)
    rise_stb |-> (!scl_oe && $past(scl_oe)));

  // R7: strobes never overlap
  p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fall_stb, rise_stb, sda_stb}));

  // R10: disable releases both lines
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_oe && !sda_oe && !fall_stb && !rise_stb && !sda_stb));

  // R2: phase counter stays inside its latched limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> (cnt_q <= lim_q));

  // R5: SDA update only ever lands in a low phase
  p_sda_in_low_r5: assert property (@(posedge clk) disable iff (rst || !en)
    sda_stb |-> (state_q == ST_LOW && scl_oe));
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int DW       = 8,
  parameter int HIGH_RST = 8'h3F,
  parameter int LOW_RST  = 8'h3F,
  parameter int HOLD_RST = 8'h01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          bit_start,
  input  logic          bit_val,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          fall_stb,
  output logic          rise_stb,
  output logic          sda_stb
);
  localparam int CW = DW + 2;

  logic [DW-1:0] high_v, low_v, hold_v;
  logic [CW-1:0] low_last, high_last, sda_at;

  bt_regfile #(
    .DW(DW), .HIGH_RST(HIGH_RST), .LOW_RST(LOW_RST), .HOLD_RST(HOLD_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .high_q(high_v), .low_q(low_v), .hold_q(hold_v)
  );

  bt_phase_calc #(.DW(DW)) u_calc (
    .high_v(high_v), .low_v(low_v), .hold_v(hold_v),
    .low_last(low_last), .high_last(high_last), .sda_at(sda_at)
  );

  bt_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst), .en(en), .bit_start(bit_start), .bit_val(bit_val),
    .low_last(low_last), .high_last(high_last), .sda_at(sda_at),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .sda_stb(sda_stb)
  );
endmodule

// File: tb/sim_i2c_bit_timer.sv
`timescale 1ns/1ps
module sim_i2c_bit_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       bit_start = 1'b0;
  logic       bit_val = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       scl_oe, sda_oe, fall_stb, rise_stb, sda_stb;

  always #2 clk = ~clk;

  i2c_bit_timer u0 (
    .clk(clk), .rst(rst), .en(en), .bit_start(bit_start), .bit_val(bit_val),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .sda_stb(sda_stb)
  );

  typedef struct {
    int    kind;  // 0 fall, 1 sda, 2 rise
    int    at;
    logic  val;
    string tag;
  } ev_t;

  ev_t q[$];
  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  int  m_high = 63, m_low = 63, m_hold = 1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic take(input int kind);
    ev_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R7 strobe with no requested bit", kind, -1);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind, {e.tag, " strobe kind"}, kind, e.kind);
      chk(e.at == cyc, {e.tag, " strobe cycle"}, cyc, e.at);
      if (kind == 1) chk(sda_oe === e.val, {e.tag, " sda value"}, int'(sda_oe), int'(e.val));
    end
  endtask

  // monitor / scoreboard
  logic prev_sda = 1'b0, prev_scl = 1'b0, prev_en = 1'b0;
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (prev_en && en && sda_oe !== prev_sda)
        chk(prev_scl === 1'b1 && scl_oe === 1'b1, "R6 sda moved outside low phase",
            int'(prev_scl), 1);
      if (fall_stb) take(0);
      if (sda_stb)  take(1);
      if (rise_stb) take(2);
    end
    prev_sda = sda_oe;
    prev_scl = scl_oe;
    prev_en  = en;
  end

  task automatic wr(input int sel, input int v);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = 8'(v);
    if (sel == 0) m_high = v;
    if (sel == 1) m_low = v;
    if (sel == 2) m_hold = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // call at a negedge while idle or in the last high cycle; returns in the last high cycle
  task automatic run_bit(input logic b, input string ft, input string st, input string rt);
    int L, H, D, F, t;
    ev_t e;
    L = m_low; H = m_high; D = m_hold;
    t = (D + 2 >= 4 * L + 2) ? 4 * L + 1 : D + 2;
    F = cyc + 1;
    e.kind = 0; e.at = F;             e.val = 1'b0; e.tag = ft; q.push_back(e);
    e.kind = 1; e.at = F + t;         e.val = ~b;   e.tag = st; q.push_back(e);
    e.kind = 2; e.at = F + 4 * L + 2; e.val = 1'b0; e.tag = rt; q.push_back(e);
    bit_start = 1'b1; bit_val = b;
    @(negedge clk);
    bit_start = 1'b0;
    while (cyc != F + 4 * L + 4 * H + 3) @(negedge clk);
  endtask

  task automatic idle_chk(input int n);
    repeat (n) @(negedge clk);
    chk(scl_oe === 1'b0, "R8 clock released when idle", int'(scl_oe), 0);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_oe === 1'b0, "R1 scl_oe after reset", int'(scl_oe), 0);
    chk(sda_oe === 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);

    // default settings
    run_bit(1'b0, "R1", "R1", "R1");
    idle_chk(5);

    // back-to-back bits
    wr(1, 2); wr(0, 1); wr(2, 3);
    run_bit(1'b1, "R7", "R4", "R2");
    run_bit(1'b0, "R3", "R4", "R2");
    run_bit(1'b1, "R8", "R4", "R2");
    idle_chk(6);

    // hold clamp at and past the low-phase end
    wr(1, 1); wr(2, 4);
    run_bit(1'b0, "R7", "R5", "R2");
    idle_chk(3);
    wr(2, 20);
    run_bit(1'b1, "R7", "R5", "R2");
    idle_chk(3);
    wr(2, 2);
    run_bit(1'b0, "R7", "R4", "R2");
    idle_chk(3);

    // minimum settings
    wr(0, 0); wr(1, 0); wr(2, 0);
    run_bit(1'b0, "R7", "R5", "R2");
    run_bit(1'b1, "R3", "R5", "R2");
    run_bit(1'b0, "R3", "R5", "R2");
    idle_chk(4);

    // writes in the middle of a phase
    wr(1, 2); wr(0, 1); wr(2, 1);
    fork
      run_bit(1'b0, "R7", "R4", "R2");
      begin repeat (3) @(negedge clk); wr(1, 5); end
    join
    run_bit(1'b1, "R9", "R4", "R9");
    fork
      run_bit(1'b0, "R9", "R4", "R2");
      begin repeat (25) @(negedge clk); wr(0, 4); end
    join
    run_bit(1'b1, "R9", "R4", "R2");
    run_bit(1'b0, "R9", "R4", "R2");
    idle_chk(8);

    // enable dropped mid-bit
    wr(1, 3); wr(0, 1); wr(2, 1);
    begin
      ev_t e;
      int F;
      F = cyc + 1;
      e.kind = 0; e.at = F;     e.val = 1'b0; e.tag = "R10"; q.push_back(e);
      e.kind = 1; e.at = F + 3; e.val = 1'b1; e.tag = "R10"; q.push_back(e);
      bit_start = 1'b1; bit_val = 1'b0;
      @(negedge clk);
      bit_start = 1'b0;
      repeat (5) @(negedge clk);
      en = 1'b0;
      q.delete();
      @(negedge clk);
      chk(scl_oe === 1'b0, "R10 scl_oe released on disable", int'(scl_oe), 0);
      chk(sda_oe === 1'b0, "R10 sda_oe released on disable", int'(sda_oe), 0);
      bit_start = 1'b1;
      repeat (3) @(negedge clk);
      bit_start = 1'b0;
      repeat (10) @(negedge clk);
      chk(scl_oe === 1'b0, "R10 request ignored while disabled", int'(scl_oe), 0);
      en = 1'b1;
      repeat (3) @(negedge clk);
      run_bit(1'b1, "R10", "R4", "R2");
      idle_chk(4);
    end

    chk(q.size() == 0, "R7 expected strobes missing", q.size(), 0);
    report();
  end
endmodule